// File: doc/BRIEF.md
# Slot Status Event Counter

This block tallies slot-level status events for a time-triggered bus controller. At the end of every slot the protocol logic raises a one-clock status strobe together with the slot's report: a valid-frame flag, the sync, null and startup indicators of the received header, and four error flags (content error, syntax error, boundary violation, transmit conflict). A stored configuration word decides which reports count.

Two conditions are evaluated on each strobe. The frame condition is armed by any of four restriction enables; each enabled restriction must hold, and all of them are ANDed together. The error condition is the OR of the error flags that a four-bit mask selects. A strobe whose report meets either condition adds one to a 16-bit counter. A mode bit picks the accumulation scheme. Single-cycle mode clears the counter at each communication cycle start. Multicycle mode keeps counting across cycles and holds at the top value. At each cycle start the running count is copied into a snapshot register, so software can read the total of the cycle that just ended. Because the null, sync and startup indicators only mean something for a valid frame, software is expected to set the valid-frame restriction whenever it uses the frame condition.

Top module: `slot_event_counter`

## Requirements
- R1: After synchronous reset, `evt_count`, `evt_snapshot` and `cfg_rd` are all zero.
- R2: A clock with `cfg_we` high stores `cfg_wdata` into the configuration (readable on `cfg_rd` from the next clock) and clears `evt_count` to zero; a status strobe in that same clock is not counted.
- R3: When configuration bits 7:4 are all zero, the frame condition is false whatever the status report is.
- R4: Frame restrictions, each active when its bit is 1: bit 4 needs `st_valid`=1, bit 5 needs `st_sync`=1, bit 6 needs `st_null`=0, bit 7 needs `st_startup`=1; the frame condition is true only when every active restriction holds.
- R5: The error condition is true when any masked flag is set: configuration bit 3 selects `st_content_err`, bit 2 `st_syntax_err`, bit 1 `st_boundary_err`, bit 0 `st_tx_conflict`.
- R6: `evt_count` rises by exactly one in the clock after a strobe whose report meets the frame condition or the error condition; without a strobe, or when neither condition holds, it does not change.
- R7: With configuration bit 8 = 0 (single-cycle mode), a `cycle_start` pulse clears `evt_count`.
- R8: With configuration bit 8 = 1 (multicycle mode), `cycle_start` leaves `evt_count` unchanged.
- R9: `evt_count` holds at 0xFFFF once it gets there, however many counting strobes follow.
- R10: On a `cycle_start` pulse, `evt_snapshot` takes the value `evt_count` had just before that pulse was applied.
- R11: When a counting strobe and `cycle_start` come in the same clock, the cycle-start step happens first and the increment goes to the new cycle's count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 9 | Configuration word: [8] multicycle, [7] startup, [6] null, [5] sync, [4] valid, [3:0] error mask |
| cfg_rd | output | 9 | Stored configuration word |
| cycle_start | input | 1 | One-clock pulse at each communication cycle start |
| st_strobe | input | 1 | One-clock slot status strobe |
| st_valid | input | 1 | Valid frame received in the slot |
| st_sync | input | 1 | Sync frame indicator |
| st_null | input | 1 | Null frame indicator |
| st_startup | input | 1 | Startup frame indicator |
| st_content_err | input | 1 | Content error in the slot |
| st_syntax_err | input | 1 | Syntax error in the slot |
| st_boundary_err | input | 1 | Boundary violation in the slot |
| st_tx_conflict | input | 1 | Transmit conflict in the slot |
| evt_count | output | 16 | Running event count |
| evt_snapshot | output | 16 | Count captured at the last cycle start |

## Verification
The counting path is driven with reports that separate its pieces. With every frame enable clear, a report carrying all indicators shows that an unarmed frame condition cannot count. Reports that break one restriction at a time show the AND of restrictions and the inverted sense of the null check. Reports carrying a single error flag under a single mask bit show the mask-to-flag pairing. Cycle starts are issued alone, together with a counting strobe, and together with a configuration write, in both modes, to fix the order of snapshot, clear and increment. A long run of counting strobes in multicycle mode shows that the count holds at the top value.

// File: rtl/sec_pkg.sv
package sec_pkg;

  typedef struct packed {
    logic       multi;     // 1: accumulate across cycles
    logic       start_en;  // restrict to startup frames
    logic       null_en;   // restrict to non-null frames
    logic       sync_en;   // restrict to sync frames
    logic       valid_en;  // restrict to valid frames
    logic [3:0] err_mask;  // [3] content [2] syntax [1] boundary [0] conflict
  } sec_cfg_t;

  localparam int CFG_W = $bits(sec_cfg_t);

  typedef struct packed {
    logic content_err;
    logic syntax_err;
    logic boundary_err;
    logic tx_conflict;
    logic startup;
    logic nullf;
    logic sync;
    logic valid;
  } sec_status_t;

endpackage

// File: rtl/sec_match.sv
module sec_match
  import sec_pkg::*;
(
  input  sec_cfg_t    cfg,
  input  sec_status_t st,
  output logic        frame_hit,
  output logic        err_hit
);

  localparam int NRES = 4;

  logic [NRES-1:0] res_en;
  logic [NRES-1:0] res_ok;
  logic [3:0]      err_flags;

  assign res_en    = {cfg.start_en, cfg.null_en, cfg.sync_en, cfg.valid_en};
  assign res_ok    = {st.startup, ~st.nullf, st.sync, st.valid};
  assign err_flags = {st.content_err, st.syntax_err, st.boundary_err, st.tx_conflict};

  logic [NRES-1:0] res_pass;

  genvar g;
  generate
    for (g = 0; g < NRES; g++) begin : g_res
      assign res_pass[g] = ~res_en[g] | res_ok[g];
    end
  endgenerate

  always_comb begin
    frame_hit = (|res_en) & (&res_pass);
    err_hit   = |(cfg.err_mask & err_flags);
  end

endmodule

// File: rtl/sec_accum.sv
module sec_accum #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             cyc,
  input  logic             multi,
  input  logic             hit,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] snap
);

  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] nxt;

  always_comb begin
    base = (cyc && !multi) ? '0 : count;
    nxt  = (hit && base != MAXV) ? base + 1'b1 : base;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      snap  <= '0;
    end else begin
      if (cyc) snap <= count;
      if (clr) count <= '0;
      else     count <= nxt;
    end
  end

  a_r9_hold_max: assert property (@(posedge clk) disable iff (rst)
    (count == MAXV && !clr && !(cyc && !multi)) |=> count == MAXV);

  a_r6_step_one: assert property (@(posedge clk) disable iff (rst)
    (!clr && !cyc) |=> (count == $past(count) || count == $past(count) + 1'b1));

  a_r6_idle_stable: assert property (@(posedge clk) disable iff (rst)
    (!clr && !cyc && !hit) |=> $stable(count));

  a_r10_snapshot: assert property (@(posedge clk) disable iff (rst)
    cyc |=> snap == $past(count));

  a_r7_single_clear: assert property (@(posedge clk) disable iff (rst)
    (cyc && !multi && !hit) |=> count == '0);

  a_r2_write_clears: assert property (@(posedge clk) disable iff (rst)
    clr |=> count == '0);

endmodule

// File: rtl/slot_event_counter.sv
module slot_event_counter
  import sec_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [8:0]       cfg_wdata,
  output logic [8:0]       cfg_rd,
  input  logic             cycle_start,
  input  logic             st_strobe,
  input  logic             st_valid,
  input  logic             st_sync,
  input  logic             st_null,
  input  logic             st_startup,
  input  logic             st_content_err,
  input  logic             st_syntax_err,
  input  logic             st_boundary_err,
  input  logic             st_tx_conflict,
  output logic [CNT_W-1:0] evt_count,
  output logic [CNT_W-1:0] evt_snapshot
);

  sec_cfg_t    cfg_q;
  sec_status_t st;
  logic        frame_hit;
  logic        err_hit;
  logic        hit;

  always_ff @(posedge clk) begin
    if (rst)         cfg_q <= '0;
    else if (cfg_we) cfg_q <= sec_cfg_t'(cfg_wdata);
  end

  assign cfg_rd = cfg_q;

  assign st = '{content_err:  st_content_err,
                syntax_err:   st_syntax_err,
                boundary_err: st_boundary_err,
                tx_conflict:  st_tx_conflict,
                startup:      st_startup,
                nullf:        st_null,
                sync:         st_sync,
                valid:        st_valid};

  sec_match u_match (
    .cfg       (cfg_q),
    .st        (st),
    .frame_hit (frame_hit),
    .err_hit   (err_hit)
  );

  assign hit = st_strobe & (frame_hit | err_hit);

  sec_accum #(.CNT_W(CNT_W)) u_accum (
    .clk   (clk),
    .rst   (rst),
    .clr   (cfg_we),
    .cyc   (cycle_start),
    .multi (cfg_q.multi),
    .hit   (hit),
    .count (evt_count),
    .snap  (evt_snapshot)
  );

  a_r3_unarmed: assert property (@(posedge clk) disable iff (rst)
    (st_strobe && !cycle_start && !cfg_we && cfg_q[7:4] == 4'b0 &&
     (cfg_q[3:0] & {st_content_err, st_syntax_err, st_boundary_err, st_tx_conflict}) == 4'b0)
    |=> $stable(evt_count));

  a_r8_multi_keep: assert property (@(posedge clk) disable iff (rst)
    (cycle_start && cfg_q.multi && !cfg_we && !st_strobe) |=> $stable(evt_count));

  a_r2_cfg_load: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> cfg_rd == $past(cfg_wdata));

  a_r11_cycle_first: assert property (@(posedge clk) disable iff (rst)
    (cycle_start && !cfg_q.multi && !cfg_we && hit) |=> evt_count == 1);

endmodule

// File: tb/slot_event_counter_test.sv
`timescale 1ns/1ps
module slot_event_counter_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [8:0]  cfg_wdata = '0;
  logic        cycle_start = 1'b0;
  logic        st_strobe = 1'b0;
  logic [7:0]  st = '0; // [7] content [6] syntax [5] boundary [4] conflict [3] startup [2] null [1] sync [0] valid
  logic [8:0]  cfg_rd;
  logic [15:0] evt_count, evt_snapshot;

  always #10 clk = ~clk;

  slot_event_counter uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rd(cfg_rd),
    .cycle_start(cycle_start), .st_strobe(st_strobe),
    .st_valid(st[0]), .st_sync(st[1]), .st_null(st[2]), .st_startup(st[3]),
    .st_tx_conflict(st[4]), .st_boundary_err(st[5]), .st_syntax_err(st[6]),
    .st_content_err(st[7]),
    .evt_count(evt_count), .evt_snapshot(evt_snapshot)
  );

  typedef struct {
    logic [15:0] cnt;
    logic [15:0] snap;
    logic [8:0]  cfg;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          n_chk = 0;
  int          n_bad = 0;
  logic [15:0] m_cnt = '0;
  logic [15:0] m_snap = '0;
  logic [8:0]  m_cfg = '0;

  function automatic logic counts(input logic [8:0] c, input logic [7:0] s);
    logic frame, slot;
    frame = (c[7:4] != 0) && (!c[4] || s[0]) && (!c[5] || s[1]) &&
            (!c[6] || !s[2]) && (!c[7] || s[3]);
    slot  = |(c[3:0] & s[7:4]);
    return frame || slot;
  endfunction

  task automatic step(input logic wr, input logic [8:0] wd, input logic cyc,
                      input logic stb, input logic [7:0] s, input logic chk,
                      input string tag);
    exp_t e;
    @(negedge clk);
    cfg_we = wr; cfg_wdata = wd; cycle_start = cyc; st_strobe = stb; st = s;
    @(posedge clk);
    if (cyc) m_snap = m_cnt;
    if (wr) begin
      m_cfg = wd;
      m_cnt = '0;
    end else begin
      if (cyc && !m_cfg[8]) m_cnt = '0;
      if (stb && counts(m_cfg, s) && m_cnt != 16'hFFFF) m_cnt = m_cnt + 1;
    end
    if (chk) begin
      e.cnt = m_cnt; e.snap = m_snap; e.cfg = m_cfg; e.tag = tag;
      sb.push_back(e);
    end
  endtask

  task automatic idle_cfg(input logic [8:0] wd, input string tag);
    step(1'b1, wd, 1'b0, 1'b0, 8'h00, 1'b1, tag);
  endtask

  task automatic strobe(input logic [7:0] s, input string tag);
    step(1'b0, 9'h0, 1'b0, 1'b1, s, 1'b1, tag);
  endtask

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_chk++;
      if (evt_count !== e.cnt || evt_snapshot !== e.snap || cfg_rd !== e.cfg) begin
        n_bad++;
        $display("FAIL %s: count=%h snap=%h cfg=%h expected count=%h snap=%h cfg=%h",
                 e.tag, evt_count, evt_snapshot, cfg_rd, e.cnt, e.snap, e.cfg);
      end
    end
  end

  initial begin
    #(190000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    n_chk++;
    if (evt_count !== 0 || evt_snapshot !== 0 || cfg_rd !== 0) begin
      n_bad++;
      $display("FAIL R1: count=%h snap=%h cfg=%h expected all zero",
               evt_count, evt_snapshot, cfg_rd);
    end

    // R3: nothing armed, no mask: full report does not count
    idle_cfg(9'h000, "R2");
    strobe(8'hFF, "R3");
    strobe(8'h0B, "R3");

    // R4/R6: valid-only restriction
    idle_cfg(9'h010, "R2");
    strobe(8'h01, "R4");
    strobe(8'h00, "R4");
    step(1'b0, 9'h0, 1'b0, 1'b0, 8'h01, 1'b1, "R6");
    strobe(8'h01, "R6");

    // R4: all restrictions
    idle_cfg(9'h0F0, "R2");
    strobe(8'h0B, "R4");
    strobe(8'h0F, "R4");
    strobe(8'h09, "R4");
    strobe(8'h03, "R4");
    strobe(8'h0A, "R4");

    // R5: mask pairing
    idle_cfg(9'h004, "R5");
    strobe(8'h40, "R5");
    strobe(8'h80, "R5");
    strobe(8'h30, "R5");
    idle_cfg(9'h008, "R5");
    strobe(8'h80, "R5");
    idle_cfg(9'h001, "R5");
    strobe(8'h10, "R5");
    strobe(8'h20, "R5");
    idle_cfg(9'h002, "R5");
    strobe(8'h20, "R5");

    // R6: frame OR error
    idle_cfg(9'h011, "R6");
    strobe(8'h10, "R6");
    strobe(8'h01, "R6");
    strobe(8'h11, "R6");
    strobe(8'h00, "R6");

    // R7/R10/R11: single-cycle mode
    step(1'b0, 9'h0, 1'b1, 1'b0, 8'h00, 1'b1, "R7");
    strobe(8'h01, "R7");
    strobe(8'h01, "R7");
    step(1'b0, 9'h0, 1'b1, 1'b1, 8'h01, 1'b1, "R11");
    step(1'b0, 9'h0, 1'b1, 1'b1, 8'h00, 1'b1, "R10");

    // R2: write with a counting strobe and a cycle start
    strobe(8'h01, "R6");
    step(1'b1, 9'h111, 1'b1, 1'b1, 8'h01, 1'b1, "R2");

    // R8/R11 multicycle
    strobe(8'h01, "R8");
    strobe(8'h10, "R8");
    step(1'b0, 9'h0, 1'b1, 1'b0, 8'h00, 1'b1, "R8");
    step(1'b0, 9'h0, 1'b1, 1'b1, 8'h01, 1'b1, "R11");

    // R9: saturation in multicycle mode
    idle_cfg(9'h10F, "R2");
    for (int i = 0; i < 65540; i++) step(1'b0, 9'h0, 1'b0, 1'b1, 8'h80, 1'b0, "R9");
    strobe(8'h80, "R9");
    strobe(8'h40, "R9");
    step(1'b0, 9'h0, 1'b1, 1'b1, 8'h20, 1'b1, "R9");
    step(1'b0, 9'h0, 1'b1, 1'b0, 8'h00, 1'b1, "R10");

    step(1'b0, 9'h0, 1'b0, 1'b0, 8'h00, 1'b0, "end");
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule